// File: doc/BRIEF.md
# Debug Trace Message Serializer

This block takes trace message requests from on-chip trace sources and turns each one into a stream of narrow beats on an auxiliary debug output. A request holds a message type code, the identifier of the core that raised it, a flow address and a data word. The type code decides which of the two follows the fixed header. Indirect branches and exceptions send an address, and every other code sends the data word. Each message leaves as a header field followed by one variable-length field. Both fields are shifted out least significant bit first, `PORT_W` bits per clock. A two-bit control sideband marks where the message starts, where a field ends and where the message ends.

The variable field is cut down to its significant bits and zero-filled up to a whole beat. Flow addresses are normally sent as the XOR of the new address with the address sent last, so only the changed low-order bits cost bandwidth. A periodic full-address message lets the tool resynchronise. A full address is also forced after reset and after a request has been lost. Requests use a valid/ready pair. Ready is low while a message is still being shifted. A source cannot stall, so a request offered while ready is low is dropped and a sticky overflow flag is set.

Top module: `trc_packetizer`

## Requirements
- R1: The header is the 6-bit type code in bits 5:0, then the source ID in the next `SRC_W` bits, then one form bit (1 = full address). It is zero-padded to whole beats and sent as the first field. Its first beat carries control 01, and its last beat carries control 10.
- R2: Type codes 4 (indirect branch) and 5 (exception) carry an address field. Every other code carries the data field.
- R3: The variable field is sent least significant beat first. Its length is the position of its highest set bit plus one, rounded up to whole beats, with zero padding. Its last beat carries control 11.
- R4: A variable field whose value is zero is sent as exactly one all-zero beat.
- R5: The first address message after reset is a full-address message: form bit 1 and all `ADDR_W` bits sent, untrimmed.
- R6: Any other address message, unless it is due for a full address, carries the XOR of its address with the previously sent address, trimmed as in R3, with form bit 0.
- R7: After a full-address message, the next `SYNC_PERIOD`-1 address messages are compressed, and the one after them is full again.
- R8: Ready is low from the cycle after an accepted request until the beat with control 11 is on the port. During that beat ready is high, so the next message can follow with no gap.
- R9: A request offered while ready is low is discarded. The overflow output rises on the next cycle and stays high until reset. The next address message is full.
- R10: When no message is being sent, valid is 0 and the control and data outputs are 0. This is also the state after reset.
- R11: Beats that end neither a field nor a message, and are not the first beat, carry control 00 with valid high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Trace request offered |
| req_ready | output | 1 | Serializer can take a request |
| req_tcode | input | 6 | Message type code |
| req_src | input | SRC_W | Source core identifier |
| req_addr | input | ADDR_W | Flow target address |
| req_data | input | DATA_W | Data word for non-address messages |
| aux_valid | output | 1 | Beat present on the port |
| aux_ctl | output | 2 | 01 start, 10 end of field, 11 end of message, 00 other |
| aux_data | output | PORT_W | Beat payload |
| overflow | output | 1 | Sticky: a request was lost |

## Verification
The properties assume that reset is held for at least one clocked cycle before any request, and that `req_valid` is driven to a known level on every cycle. Beyond that, a source may offer a request whenever it likes, even while ready is low. The stimulus changes inputs only between clock edges and drives the request lines for one cycle per offer. It deliberately offers a request during a transfer to reach the loss case. Apart from that, it waits for ready before each send, so every back-to-back hand-over is exercised.

// File: rtl/trc_pkg.sv
package trc_pkg;

  typedef enum logic [1:0] {
    CTL_MID = 2'b00,
    CTL_SOM = 2'b01,
    CTL_EOF = 2'b10,
    CTL_EOM = 2'b11
  } aux_ctl_e;

  localparam int TCODE_W = 6;
  localparam logic [TCODE_W-1:0] TC_INDIRECT = 6'd4;
  localparam logic [TCODE_W-1:0] TC_EXCEPT   = 6'd5;

  function automatic logic carries_addr(input logic [TCODE_W-1:0] tc);
    return (tc == TC_INDIRECT) || (tc == TC_EXCEPT);
  endfunction

endpackage

// File: rtl/trc_sigbeats.sv
module trc_sigbeats #(
  parameter int W      = 32,
  parameter int PORT_W = 4,
  parameter int BEAT_W = 4
) (
  input  logic [W-1:0]      value,
  output logic [BEAT_W-1:0] beats
);
  int nbits;

  always_comb begin
    nbits = 1;
    for (int i = 0; i < W; i++) begin
      if (value[i]) nbits = i + 1;
    end
    beats = BEAT_W'((nbits + PORT_W - 1) / PORT_W);
  end
endmodule

// File: rtl/trc_flow_track.sv
module trc_flow_track #(
  parameter int ADDR_W      = 32,
  parameter int SYNC_PERIOD = 256
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              take,
  input  logic              lost,
  input  logic [ADDR_W-1:0] addr,
  output logic              full,
  output logic [ADDR_W-1:0] delta
);
  localparam int CNT_W = (SYNC_PERIOD > 1) ? $clog2(SYNC_PERIOD) : 1;

  logic [ADDR_W-1:0] last_sent;
  logic [CNT_W-1:0]  since_full;
  logic              force_full;

  assign full  = force_full || (since_full == CNT_W'(SYNC_PERIOD - 1));
  assign delta = full ? addr : (addr ^ last_sent);

  always_ff @(posedge clk) begin
    if (rst) begin
      last_sent  <= '0;
      since_full <= '0;
      force_full <= 1'b1;
    end else begin
      if (take) begin
        last_sent <= addr;
        if (full) begin
          since_full <= '0;
          force_full <= 1'b0;
        end else begin
          since_full <= since_full + 1'b1;
        end
      end
      if (lost) force_full <= 1'b1;
    end
  end
endmodule

// File: rtl/trc_serializer.sv
module trc_serializer #(
  parameter int PORT_W   = 4,
  parameter int SR_W     = 44,
  parameter int CNT_W    = 4,
  parameter int HDR_BEAT = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [SR_W-1:0]   load_vec,
  input  logic [CNT_W-1:0]  load_beats,
  output logic              busy,
  output logic              aux_valid,
  output logic [1:0]        aux_ctl,
  output logic [PORT_W-1:0] aux_data
);
  import trc_pkg::*;

  logic [SR_W-1:0]  shreg;
  logic [CNT_W-1:0] idx;
  logic [CNT_W-1:0] total;

  always_ff @(posedge clk) begin
    if (rst) begin
      shreg     <= '0;
      idx       <= '0;
      total     <= '0;
      busy      <= 1'b0;
      aux_valid <= 1'b0;
      aux_ctl   <= CTL_MID;
      aux_data  <= '0;
    end else if (load) begin
      aux_data  <= load_vec[PORT_W-1:0];
      aux_ctl   <= CTL_SOM;
      aux_valid <= 1'b1;
      shreg     <= load_vec >> PORT_W;
      idx       <= CNT_W'(1);
      total     <= load_beats;
      busy      <= 1'b1;
    end else if (busy) begin
      aux_data  <= shreg[PORT_W-1:0];
      shreg     <= shreg >> PORT_W;
      aux_valid <= 1'b1;
      idx       <= idx + 1'b1;
      if (idx == total - 1'b1) begin
        aux_ctl <= CTL_EOM;
        busy    <= 1'b0;
      end else if (idx == CNT_W'(HDR_BEAT - 1)) begin
        aux_ctl <= CTL_EOF;
      end else begin
        aux_ctl <= CTL_MID;
      end
    end else begin
      aux_valid <= 1'b0;
      aux_ctl   <= CTL_MID;
      aux_data  <= '0;
    end
  end
endmodule

// File: rtl/trc_packetizer.sv
module trc_packetizer #(
  parameter int PORT_W      = 4,
  parameter int SRC_W       = 4,
  parameter int ADDR_W      = 32,
  parameter int DATA_W      = 16,
  parameter int SYNC_PERIOD = 256
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [5:0]        req_tcode,
  input  logic [SRC_W-1:0]  req_src,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_data,
  output logic              aux_valid,
  output logic [1:0]        aux_ctl,
  output logic [PORT_W-1:0] aux_data,
  output logic              overflow
);
  localparam int HDR_W    = trc_pkg::TCODE_W + SRC_W + 1;
  localparam int HDR_BEAT = (HDR_W + PORT_W - 1) / PORT_W;
  localparam int VAR_W    = (ADDR_W > DATA_W) ? ADDR_W : DATA_W;
  localparam int VAR_BEAT = (VAR_W + PORT_W - 1) / PORT_W;
  localparam int ADR_BEAT = (ADDR_W + PORT_W - 1) / PORT_W;
  localparam int SR_W     = (HDR_BEAT + VAR_BEAT) * PORT_W;
  localparam int CNT_W    = $clog2(HDR_BEAT + VAR_BEAT + 1);

  logic              busy, accept, lost, is_addr, sync_full, full_form;
  logic [ADDR_W-1:0] delta;
  logic [VAR_W-1:0]  var_val;
  logic [CNT_W-1:0]  trim_beats, var_beats;
  logic [HDR_W-1:0]  hdr;
  logic [SR_W-1:0]   msg_vec;

  assign req_ready = !busy;
  assign accept    = req_valid && !busy;
  assign lost      = req_valid && busy;
  assign is_addr   = trc_pkg::carries_addr(req_tcode);
  assign full_form = is_addr && sync_full;
  assign var_val   = is_addr ? VAR_W'(delta) : VAR_W'(req_data);
  assign var_beats = full_form ? CNT_W'(ADR_BEAT) : trim_beats;
  assign hdr       = {full_form, req_src, req_tcode};
  assign msg_vec   = SR_W'(hdr) | (SR_W'(var_val) << (HDR_BEAT * PORT_W));

  trc_flow_track #(.ADDR_W(ADDR_W), .SYNC_PERIOD(SYNC_PERIOD)) u_flow (
    .clk(clk), .rst(rst), .take(accept && is_addr), .lost(lost),
    .addr(req_addr), .full(sync_full), .delta(delta)
  );

  trc_sigbeats #(.W(VAR_W), .PORT_W(PORT_W), .BEAT_W(CNT_W)) u_sig (
    .value(var_val), .beats(trim_beats)
  );

  trc_serializer #(.PORT_W(PORT_W), .SR_W(SR_W), .CNT_W(CNT_W),
                   .HDR_BEAT(HDR_BEAT)) u_ser (
    .clk(clk), .rst(rst), .load(accept), .load_vec(msg_vec),
    .load_beats(CNT_W'(HDR_BEAT) + var_beats), .busy(busy),
    .aux_valid(aux_valid), .aux_ctl(aux_ctl), .aux_data(aux_data)
  );

  always_ff @(posedge clk) begin
    if (rst)       overflow <= 1'b0;
    else if (lost) overflow <= 1'b1;
  end
endmodule

// File: rtl/trc_packetizer_chk.sv
module trc_packetizer_chk #(
  parameter int PORT_W = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic              req_ready,
  input logic              aux_valid,
  input logic [1:0]        aux_ctl,
  input logic [PORT_W-1:0] aux_data,
  input logic              overflow
);
  p_accept_starts_r8: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> (aux_valid && aux_ctl == 2'b01));

  p_busy_not_ready_r8: assert property (@(posedge clk) disable iff (rst)
    (aux_valid && aux_ctl != 2'b11) |-> !req_ready);

  p_eom_ready_r8: assert property (@(posedge clk) disable iff (rst)
    (aux_valid && aux_ctl == 2'b11) |-> req_ready);

  p_no_overflow_r9: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_ready) |=> overflow);

  p_overflow_sticky_r9: assert property (@(posedge clk) disable iff (rst)
    overflow |=> overflow);

  p_idle_quiet_r10: assert property (@(posedge clk) disable iff (rst)
    !aux_valid |-> (aux_ctl == 2'b00 && aux_data == '0));

  p_start_after_gap_r1: assert property (@(posedge clk) disable iff (rst)
    (aux_valid && !$past(aux_valid)) |-> aux_ctl == 2'b01);
endmodule

bind trc_packetizer trc_packetizer_chk #(.PORT_W(PORT_W)) u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
  .aux_valid(aux_valid), .aux_ctl(aux_ctl), .aux_data(aux_data),
  .overflow(overflow)
);

// File: tb/trc_packetizer_bench.sv
module trc_packetizer_bench;
  localparam int P = 4, S = 4, A = 32, D = 16, HB = 3, PER = 256;

  logic clk = 1'b0, rst = 1'b1;
  logic req_valid = 1'b0;
  logic req_ready;
  logic [5:0] req_tcode = '0;
  logic [S-1:0] req_src = '0;
  logic [A-1:0] req_addr = '0;
  logic [D-1:0] req_data = '0;
  logic aux_valid, overflow;
  logic [1:0] aux_ctl;
  logic [P-1:0] aux_data;

  always #2.5 clk = ~clk;

  trc_packetizer #(.PORT_W(P), .SRC_W(S), .ADDR_W(A), .DATA_W(D),
                   .SYNC_PERIOD(PER)) u_trc_packetizer (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_tcode(req_tcode), .req_src(req_src), .req_addr(req_addr),
    .req_data(req_data), .aux_valid(aux_valid), .aux_ctl(aux_ctl),
    .aux_data(aux_data), .overflow(overflow)
  );

  int errors = 0, checks = 0;
  bit done = 1'b0;
  logic [6:0] q_beat[$];
  string q_tag[$];
  logic [A-1:0] m_last = '0;
  int m_cnt = 0;
  bit m_pend = 1'b1, m_ovf = 1'b0;

  task automatic chk(bit ok, string tag, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic int sig_bits(logic [63:0] v);
    int n = 1;
    for (int i = 0; i < 64; i++) if (v[i]) n = i + 1;
    return n;
  endfunction

  task automatic build(logic [5:0] tc, logic [S-1:0] s, logic [A-1:0] a,
                       logic [D-1:0] d, string tag);
    bit is_addr = (tc == 6'd4) || (tc == 6'd5);
    bit full = 1'b0;
    logic [63:0] val;
    logic [63:0] hdr;
    int nb, vb;
    if (is_addr) begin
      full = m_pend || (m_cnt == PER - 1);
      val = full ? 64'(a) : 64'(a ^ m_last);
      m_last = a;
      if (full) begin m_cnt = 0; m_pend = 1'b0; end else m_cnt++;
      nb = full ? A : sig_bits(val);
    end else begin
      val = 64'(d);
      nb = sig_bits(val);
    end
    vb = (nb + P - 1) / P;
    hdr = 64'({full, s, tc});
    for (int i = 0; i < HB + vb; i++) begin
      logic [1:0] c;
      logic [P-1:0] b;
      b = (i < HB) ? P'(hdr >> (P * i)) : P'(val >> (P * (i - HB)));
      if (i == 0) c = 2'b01;
      else if (i == HB + vb - 1) c = 2'b11;
      else if (i == HB - 1) c = 2'b10;
      else c = 2'b00;
      q_beat.push_back({1'b1, c, b});
      q_tag.push_back(tag);
    end
  endtask

  task automatic step(bit v, logic [5:0] tc, logic [S-1:0] s, logic [A-1:0] a,
                      logic [D-1:0] d, string tag);
    logic [6:0] e;
    string t;
    @(negedge clk);
    if (q_beat.size() > 0) begin
      e = q_beat.pop_front();
      t = {q_tag.pop_front(), " R1 R3 R11"};
    end else begin
      e = '0;
      t = "R10";
    end
    chk(aux_valid == e[6], t, "valid", int'(aux_valid), int'(e[6]));
    chk(aux_ctl == e[5:4], t, "ctl", int'(aux_ctl), int'(e[5:4]));
    chk(aux_data == e[3:0], t, "data", int'(aux_data), int'(e[3:0]));
    chk(req_ready == (q_beat.size() == 0), "R8", "ready",
        int'(req_ready), int'(q_beat.size() == 0));
    chk(overflow == m_ovf, "R9", "overflow", int'(overflow), int'(m_ovf));
    req_valid = v; req_tcode = tc; req_src = s; req_addr = a; req_data = d;
    if (v) begin
      if (q_beat.size() == 0) build(tc, s, a, d, tag);
      else begin m_ovf = 1'b1; m_pend = 1'b1; end
    end
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step(1'b0, '0, '0, '0, '0, "R10");
  endtask

  task automatic send(logic [5:0] tc, logic [S-1:0] s, logic [A-1:0] a,
                      logic [D-1:0] d, string tag);
    while (q_beat.size() > 1) step(1'b0, '0, '0, '0, '0, tag);
    step(1'b1, tc, s, a, d, tag);
  endtask

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    idle(2);                                              // R10 reset state
    send(6'd4, 4'h3, 32'h1234_5678, '0, "R2 R5");         // first: full
    send(6'd5, 4'h9, 32'h1234_5679, '0, "R2 R6");         // XOR = 1
    send(6'd4, 4'h1, 32'h1234_5679, '0, "R4 R6");         // XOR = 0
    send(6'd2, 4'hA, '0, 16'hABCD, "R2 R3");              // data, 4 beats
    send(6'd7, 4'h2, '0, 16'h0000, "R4");                 // zero data
    send(6'd1, 4'hF, '0, 16'h0010, "R3");                 // 2 beats
    send(6'd4, 4'h6, 32'h8000_0000, '0, "R6");            // wide delta
    idle(3);
    step(1'b1, 6'd3, 4'h5, '0, 16'h00FF, "R9");           // accepted
    step(1'b1, 6'd4, 4'h5, 32'hDEAD_BEEF, '0, "R9");      // dropped
    send(6'd5, 4'h4, 32'h0000_0010, '0, "R9 R5");         // full after loss
    for (int k = 0; k < PER + 4; k++)
      send(6'd4, 4'h7, 32'h0000_0010 + 32'(k * 3), '0, "R7");
    while (q_beat.size() > 0) idle(1);
    idle(2);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule